// File: doc/BRIEF.md
# Trapping Integer ALU with Sticky Carry

This block is an integer arithmetic and logic unit with a carry flag that persists from one operation to the next. Each accepted request carries two operands, an operation code and a condition selector. One clock later the block presents the result and a trap flag. The trap flag is raised when the selected condition holds on that operation's result or side flags.

The carry flag feeds the signed and unsigned add and subtract operations as their carry-in. It is committed only when the operation does not trap. This lets a trapping instruction be restarted without its carry side effect having taken place.

Besides plain signed and unsigned arithmetic, the unit offers a tagged add and subtract that check the top bits of both operands and the result for a consistent tag. It also offers an add and subtract that ignore the carry, the three bitwise logic operations, and an unsigned bounds check.

Top module: `alu_trap_unit`

## Requirements
- R1: A synchronous reset clears the carry flag to 0 and drops `out_valid`.
- R2: Every cycle with `in_valid` high produces exactly one cycle of `out_valid`, on the following cycle, with that request's `result` and `trap`. `trap` is 0 whenever `out_valid` is 0.
- R3: Signed add (op 0) gives A+B+carry. Signed subtract (op 2) gives A+~B+~carry. Signed add overflows when A and B share a sign and the result's sign differs. Signed subtract overflows when A and B differ in sign and the result's sign differs from A's. Both write 0 to the carry flag.
- R4: Unsigned add (op 1) computes A+B+carry and takes the adder carry-out as the new carry. Unsigned subtract (op 3) computes A+~B+~carry and takes the inverted adder carry-out, a borrow, as the new carry.
- R5: Tagged add (op 4) gives A+B and tagged subtract (op 5) gives A-B, both ignoring the carry. Each raises the tag-fault flag if the top TAG_BITS bits of A, of B or of the result are not all equal. Both write 0 to the carry flag.
- R6: Carry-ignoring add (op 6) gives A+B and carry-ignoring subtract (op 7) gives A-B. The carry flag keeps its value.
- R7: AND (op 8), OR (op 9) and XOR (op 10) never raise `trap`, whatever the selector, and leave the carry flag unchanged.
- R8: Bounds check (op 11) returns A unchanged. Its bounds flag is 1 when A >= B unsigned. The carry flag keeps its value.
- R9: The condition selector codes are as follows. 0 = never, 1 = result zero, 2 = result negative, 3 = result <= 0, 4 = always, 5 = result nonzero, 6 = result >= 0, 7 = result > 0, 8 = overflow, 9 = no overflow, 10 = bounds, 11 = no bounds, 12 = tag fault, 13 = no tag fault. Codes 14 and 15 never trap. Comparisons are signed. The overflow, bounds and tag flags are 0 for operations that do not define them.
- R10: The carry flag takes its new value only for a request that does not raise `trap`. A trapping request leaves it unchanged.
- R11: Reserved op codes 12 to 15 return 0, never trap and leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| op | input | 4 | Operation code |
| cond_sel | input | 4 | Trap condition selector |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | WIDTH | Operation result |
| trap | output | 1 | Selected condition held on this result |
| carry | output | 1 | Current carry flag |

## Verification
The bench builds the unit with WIDTH = 32 and TAG_BITS = 3. At these values the signed overflow edges (0x7FFFFFFF + 1, 0x80000000 - 1) and the unsigned wrap at 0xFFFFFFFF fall within reach of short directed vectors. A tag fault can be provoked by setting only bit 29. Random operands and codes then sweep every op and selector pair. Carry chains run across consecutive requests, so a carry committed by one request is observed as the carry-in of the next.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;

    localparam int OPW   = 4;
    localparam int CONDW = 4;

    localparam logic [OPW-1:0] OP_ADD_S  = 4'd0;
    localparam logic [OPW-1:0] OP_ADD_U  = 4'd1;
    localparam logic [OPW-1:0] OP_SUB_S  = 4'd2;
    localparam logic [OPW-1:0] OP_SUB_U  = 4'd3;
    localparam logic [OPW-1:0] OP_ADD_T  = 4'd4;
    localparam logic [OPW-1:0] OP_SUB_T  = 4'd5;
    localparam logic [OPW-1:0] OP_ADD_V  = 4'd6;
    localparam logic [OPW-1:0] OP_SUB_V  = 4'd7;
    localparam logic [OPW-1:0] OP_AND    = 4'd8;
    localparam logic [OPW-1:0] OP_OR     = 4'd9;
    localparam logic [OPW-1:0] OP_XOR    = 4'd10;
    localparam logic [OPW-1:0] OP_BCHK   = 4'd11;

    localparam logic [CONDW-1:0] C_NEVER  = 4'd0;
    localparam logic [CONDW-1:0] C_ZERO   = 4'd1;
    localparam logic [CONDW-1:0] C_NEG    = 4'd2;
    localparam logic [CONDW-1:0] C_LE0    = 4'd3;
    localparam logic [CONDW-1:0] C_ALWAYS = 4'd4;
    localparam logic [CONDW-1:0] C_NZERO  = 4'd5;
    localparam logic [CONDW-1:0] C_GE0    = 4'd6;
    localparam logic [CONDW-1:0] C_GT0    = 4'd7;
    localparam logic [CONDW-1:0] C_OVF    = 4'd8;
    localparam logic [CONDW-1:0] C_NOVF   = 4'd9;
    localparam logic [CONDW-1:0] C_BND    = 4'd10;
    localparam logic [CONDW-1:0] C_NBND   = 4'd11;
    localparam logic [CONDW-1:0] C_TAG    = 4'd12;
    localparam logic [CONDW-1:0] C_NTAG   = 4'd13;

    typedef struct packed {
        logic ovf;
        logic bnd;
        logic tag;
    } side_flags_t;

endpackage

// File: rtl/alu_trap_adder.sv
module alu_trap_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int EXTW = WIDTH + 1;

    logic [EXTW-1:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + EXTW'(cin);
        sum  = wide[WIDTH-1:0];
        cout = wide[WIDTH];
    end
endmodule

// File: rtl/alu_trap_tagchk.sv
module alu_trap_tagchk #(
    parameter int WIDTH    = 32,
    parameter int TAG_BITS = 3
) (
    input  logic [WIDTH-1:0] value,
    output logic             uniform
);
    localparam int LSB = WIDTH - TAG_BITS;

    logic [TAG_BITS-1:0] top;

    always_comb begin
        top     = value[WIDTH-1:LSB];
        uniform = (&top) | ~(|top);
    end
endmodule

// File: rtl/alu_trap_cond.sv
module alu_trap_cond
    import alu_trap_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [CONDW-1:0] sel,
    input  logic [WIDTH-1:0] value,
    input  side_flags_t      flags,
    output logic             hit
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (value == '0);
        is_neg  = value[WIDTH-1];
        unique case (sel)
            C_NEVER:  hit = 1'b0;
            C_ZERO:   hit = is_zero;
            C_NEG:    hit = is_neg;
            C_LE0:    hit = is_neg | is_zero;
            C_ALWAYS: hit = 1'b1;
            C_NZERO:  hit = ~is_zero;
            C_GE0:    hit = ~is_neg;
            C_GT0:    hit = ~is_neg & ~is_zero;
            C_OVF:    hit = flags.ovf;
            C_NOVF:   hit = ~flags.ovf;
            C_BND:    hit = flags.bnd;
            C_NBND:   hit = ~flags.bnd;
            C_TAG:    hit = flags.tag;
            C_NTAG:   hit = ~flags.tag;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_trap_unit.sv
module alu_trap_unit
    import alu_trap_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int TAG_BITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       op,
    input  logic [3:0]       cond_sel,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             trap,
    output logic             carry
);
    localparam int MSB    = WIDTH - 1;
    localparam int NCHECK = 3;

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] res;
        logic             trp;
        logic             cy;
    } state_t;

    state_t st_d, st_q;

    logic [WIDTH-1:0] add_b;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;

    logic [WIDTH-1:0] res_c;
    side_flags_t      flg_c;
    logic             cy_new_c;
    logic             cy_wr_c;
    logic             may_trap_c;
    logic             cond_hit;
    logic             trap_c;

    logic [WIDTH-1:0]  chk_in [NCHECK];
    logic [NCHECK-1:0] chk_ok;

    alu_trap_adder #(.WIDTH(WIDTH)) i_adder (
        .a    (opa),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    assign chk_in[0] = opa;
    assign chk_in[1] = opb;
    assign chk_in[2] = add_sum;

    for (genvar g = 0; g < NCHECK; g++) begin : g_tag
        alu_trap_tagchk #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) i_tag (
            .value   (chk_in[g]),
            .uniform (chk_ok[g])
        );
    end

    alu_trap_cond #(.WIDTH(WIDTH)) i_cond (
        .sel   (cond_sel),
        .value (res_c),
        .flags (flg_c),
        .hit   (cond_hit)
    );

    // Operand steering, result select and side flags.
    always_comb begin
        add_b      = opb;
        add_cin    = 1'b0;
        res_c      = add_sum;
        flg_c      = '0;
        cy_new_c   = 1'b0;
        cy_wr_c    = 1'b0;
        may_trap_c = 1'b1;
        unique case (op)
            OP_ADD_S: begin
                add_cin   = st_q.cy;
                flg_c.ovf = (opa[MSB] == opb[MSB]) && (add_sum[MSB] != opa[MSB]);
                cy_wr_c   = 1'b1;
            end
            OP_ADD_U: begin
                add_cin  = st_q.cy;
                cy_new_c = add_cout;
                cy_wr_c  = 1'b1;
            end
            OP_SUB_S: begin
                add_b     = ~opb;
                add_cin   = ~st_q.cy;
                flg_c.ovf = (opa[MSB] != opb[MSB]) && (add_sum[MSB] != opa[MSB]);
                cy_wr_c   = 1'b1;
            end
            OP_SUB_U: begin
                add_b    = ~opb;
                add_cin  = ~st_q.cy;
                cy_new_c = ~add_cout;
                cy_wr_c  = 1'b1;
            end
            OP_ADD_T: begin
                flg_c.tag = ~(&chk_ok);
                cy_wr_c   = 1'b1;
            end
            OP_SUB_T: begin
                add_b     = ~opb;
                add_cin   = 1'b1;
                flg_c.tag = ~(&chk_ok);
                cy_wr_c   = 1'b1;
            end
            OP_ADD_V: begin
            end
            OP_SUB_V: begin
                add_b   = ~opb;
                add_cin = 1'b1;
            end
            OP_AND: begin
                res_c      = opa & opb;
                may_trap_c = 1'b0;
            end
            OP_OR: begin
                res_c      = opa | opb;
                may_trap_c = 1'b0;
            end
            OP_XOR: begin
                res_c      = opa ^ opb;
                may_trap_c = 1'b0;
            end
            OP_BCHK: begin
                add_b     = ~opb;
                add_cin   = 1'b1;
                res_c     = opa;
                flg_c.bnd = add_cout;
            end
            default: begin
                res_c      = '0;
                may_trap_c = 1'b0;
            end
        endcase
        trap_c = may_trap_c & cond_hit;
    end

    // Next-state computation.
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.trp = 1'b0;
        if (in_valid) begin
            st_d.res = res_c;
            st_d.trp = trap_c;
            if (cy_wr_c && !trap_c) begin
                st_d.cy = cy_new_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign trap      = st_q.trp;
    assign carry     = st_q.cy;
endmodule

// File: rtl/alu_trap_unit_chk.sv
module alu_trap_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] opa,
    input logic [3:0]       op,
    input logic [3:0]       cond_sel,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             trap,
    input logic             carry
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !carry));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_no_trap_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !trap);

    p_logic_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd8 || op == 4'd9 || op == 4'd10)) |=> (!trap && $stable(carry)));

    p_bounds_passthru_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd11) |=> (result == $past(opa) && $stable(carry)));

    p_never_cond_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_sel == 4'd0) |=> !trap);

    p_trap_keeps_carry_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && trap) |-> carry == $past(carry));

    p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'd12) |=> (!trap && result == '0 && $stable(carry)));
endmodule

bind alu_trap_unit alu_trap_unit_chk #(.WIDTH(WIDTH)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opa       (opa),
    .op        (op),
    .cond_sel  (cond_sel),
    .out_valid (out_valid),
    .result    (result),
    .trap      (trap),
    .carry     (carry)
);

// File: tb/test_alu_trap_unit.sv
`timescale 1ns/1ps
module test_alu_trap_unit;
    localparam int W  = 32;
    localparam int TB = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [3:0]    op = '0;
    logic [3:0]    cond_sel = '0;
    logic          out_valid;
    logic [W-1:0]  result;
    logic          trap;
    logic          carry;

    int n_checks = 0;
    int n_fail   = 0;
    logic m_carry = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         trp;
        logic         cy;
        string        req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    alu_trap_unit #(.WIDTH(W), .TAG_BITS(TB)) i_alu_trap_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .op(op), .cond_sel(cond_sel), .out_valid(out_valid),
        .result(result), .trap(trap), .carry(carry)
    );

    function automatic logic tag_ok(input logic [W-1:0] v);
        return (v[W-1:W-TB] == '0) || (v[W-1:W-TB] == '1);
    endfunction

    task automatic model(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] o, input logic [3:0] c,
                         output exp_t e);
        logic [W:0] s;
        logic ovf, bnd, tg, mt, wr, nc, hit, z, n;
        ovf = 0; bnd = 0; tg = 0; mt = 1; wr = 0; nc = 0; s = '0;
        case (o)
            4'd0: begin s = {1'b0,a} + {1'b0,b} + (W+1)'(m_carry);
                  ovf = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]); wr = 1; end
            4'd1: begin s = {1'b0,a} + {1'b0,b} + (W+1)'(m_carry); wr = 1; nc = s[W]; end
            4'd2: begin s = {1'b0,a} + {1'b0,~b} + (W+1)'(!m_carry);
                  ovf = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]); wr = 1; end
            4'd3: begin s = {1'b0,a} + {1'b0,~b} + (W+1)'(!m_carry); wr = 1; nc = !s[W]; end
            4'd4: begin s = {1'b0,a + b}; wr = 1;
                  tg = !(tag_ok(a) && tag_ok(b) && tag_ok(s[W-1:0])); end
            4'd5: begin s = {1'b0,a - b}; wr = 1;
                  tg = !(tag_ok(a) && tag_ok(b) && tag_ok(s[W-1:0])); end
            4'd6: s = {1'b0,a + b};
            4'd7: s = {1'b0,a - b};
            4'd8: begin s = {1'b0,a & b}; mt = 0; end
            4'd9: begin s = {1'b0,a | b}; mt = 0; end
            4'd10: begin s = {1'b0,a ^ b}; mt = 0; end
            4'd11: begin s = {1'b0,a}; bnd = (a >= b); end
            default: begin s = '0; mt = 0; end
        endcase
        z = (s[W-1:0] == '0);
        n = s[W-1];
        case (c)
            4'd0: hit = 0;   4'd1: hit = z;     4'd2: hit = n;
            4'd3: hit = n|z; 4'd4: hit = 1;     4'd5: hit = !z;
            4'd6: hit = !n;  4'd7: hit = !n&&!z; 4'd8: hit = ovf;
            4'd9: hit = !ovf; 4'd10: hit = bnd; 4'd11: hit = !bnd;
            4'd12: hit = tg; 4'd13: hit = !tg;  default: hit = 0;
        endcase
        e.res = s[W-1:0];
        e.trp = mt && hit;
        if (wr && !e.trp) m_carry = nc;
        e.cy = m_carry;
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] o, input logic [3:0] c, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1; opa = a; opb = b; op = o; cond_sel = c;
        model(a, b, o, c, e);
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic check_quiet(input string req);
        n_checks++;
        if (out_valid !== 1'b0 || trap !== 1'b0 || carry !== m_carry) begin
            n_fail++;
            $display("FAIL %s: out_valid=%b trap=%b carry=%b expected 0 0 %b",
                     req, out_valid, trap, carry, m_carry);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected out_valid, result=%h expected no output", result);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result !== e.res || trap !== e.trp || carry !== e.cy) begin
                    n_fail++;
                    $display("FAIL %s: got res=%h trap=%b carry=%b expected res=%h trap=%b carry=%b",
                             e.req, result, trap, carry, e.res, e.trp, e.cy);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check_quiet("R1");

        // R4 unsigned add sets carry from carry-out
        drive(32'hFFFF_FFFF, 32'h1, 4'd1, 4'd0, "R4");
        // R3 signed add uses carry-in, clears carry
        drive(32'h1, 32'h2, 4'd0, 4'd0, "R3");
        drive(32'h7FFF_FFFF, 32'h1, 4'd0, 4'd8, "R3");
        drive(32'h8000_0000, 32'h1, 4'd2, 4'd8, "R3");
        drive(32'h8000_0000, 32'h1, 4'd2, 4'd9, "R3");
        // R4 unsigned subtract borrow chain
        drive(32'h0, 32'h1, 4'd3, 4'd0, "R4");
        drive(32'h5, 32'h2, 4'd3, 4'd0, "R4");
        // R6 carry-ignoring keeps carry
        drive(32'hFFFF_FFFF, 32'h1, 4'd1, 4'd0, "R6");
        drive(32'h3, 32'h4, 4'd6, 4'd0, "R6");
        drive(32'h3, 32'h4, 4'd7, 4'd2, "R6");
        // R7 logic never traps
        drive(32'hF0F0_0000, 32'h0FF0_FFFF, 4'd8, 4'd4, "R7");
        drive(32'hF0F0_0000, 32'h0FF0_FFFF, 4'd9, 4'd4, "R7");
        drive(32'hF0F0_0000, 32'hF0F0_0000, 4'd10, 4'd1, "R7");
        // R8 bounds check
        drive(32'h5, 32'h5, 4'd11, 4'd10, "R8");
        drive(32'h4, 32'h5, 4'd11, 4'd11, "R8");
        drive(32'h4, 32'h5, 4'd11, 4'd10, "R8");
        drive(32'hFFFF_FFFF, 32'h0, 4'd11, 4'd10, "R8");
        // R5 tagged ops (carry is 1 here, tagged ignores it and clears it)
        drive(32'h1, 32'h2, 4'd4, 4'd12, "R5");
        drive(32'h2000_0000, 32'h1, 4'd4, 4'd12, "R5");
        drive(32'h1FFF_FFFF, 32'h1, 4'd4, 4'd13, "R5");
        drive(32'hE000_0000, 32'h1, 4'd5, 4'd12, "R5");
        drive(32'h5, 32'h7, 4'd5, 4'd12, "R5");
        // R10 trapping unsigned add leaves carry unchanged
        drive(32'hFFFF_FFFF, 32'h1, 4'd1, 4'd1, "R10");
        drive(32'hFFFF_FFFF, 32'h1, 4'd1, 4'd5, "R10");
        drive(32'h0, 32'h0, 4'd3, 4'd1, "R10");
        // R11 reserved codes
        for (int k = 12; k < 16; k++) drive(32'hDEAD_BEEF, 32'h1234, 4'(k), 4'd4, "R11");
        // R9 every selector on zero, negative and positive results
        for (int c = 0; c < 16; c++) begin
            drive(32'h0, 32'h0, 4'd6, 4'(c), "R9");
            drive(32'h0, 32'h1, 4'd7, 4'(c), "R9");
            drive(32'h9, 32'h0, 4'd6, 4'(c), "R9");
        end
        idle();
        idle();
        check_quiet("R2");

        // R1 reset clears a set carry
        drive(32'hFFFF_FFFF, 32'h1, 4'd1, 4'd0, "R1");
        idle();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_carry = 0;
        check_quiet("R1");

        // Random sweep across all codes
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] a, b;
            a = $urandom();
            b = $urandom();
            if (i % 5 == 0) a = {{TB{a[W-1]}}, a[W-TB-1:0]};
            if (i % 7 == 0) b = b >> 28;
            drive(a, b, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), "R9");
            if (i % 11 == 0) idle();
        end
        idle();
        idle();
        check_quiet("R2");
        if (sb.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        finish_run();
    end
endmodule